// File: doc/BRIEF.md
# Link Power Status Interface Manager

This block sits between the physical-layer core of a serial-bus node and the link-layer controller. It handles the power handshake between them. The block watches the link's power status input and measures how long that input stays low. Two low-time thresholds decide how far the interface is shut down. A short low pulse changes nothing. A low longer than the first threshold puts the interface into a reset state. In that state the control and data outputs to the link are held at zero and the link request input is ignored, but the clock enable to the link stays on. A low longer than the second threshold also turns the clock enable off. When the status input is seen high again, the interface resumes. If it resumes from the deeper state that the threshold caused, a one-cycle bus-reset request is issued so the node can announce that its link is reachable again.

The block also drives a link-on wake output. This output is a square wave that asks a sleeping link to power up. It is started by a link-on packet addressed to this node, by a pending interrupt when interrupt wake is enabled, or by a power-on event at a low power class. It stops when the link becomes active. It also stops on a bus reset, unless an enabled interrupt is still pending. All times are counted in system clock cycles and set by parameters.

Top module: `lps_link_mgr`

## Requirements
- R1: A low on `lps_in` that lasts no more than `RST_CYC` cycles leaves the interface fully active: core control, data and request keep passing to the link and no bus-reset request is made.
- R2: Once `lps_in` has been low for more than `RST_CYC` cycles, `link_ctl`, `link_data` and `link_req_out` are 0 whatever the core and link drive, while `link_clk_en` stays 1.
- R3: Once `lps_in` has been low for more than `DIS_CYC` cycles (`DIS_CYC` > `RST_CYC`), `link_clk_en` is 0 in addition to the gating of R2.
- R4: When `lps_in` is high again in either low-power state, the interface returns to passing core control, data and request within a few cycles, and `link_clk_en` returns to 1.
- R5: After hardware reset the interface is in the disabled state, with `link_clk_en` 0 and all link outputs 0, until `lps_in` is seen high.
- R6: `bus_reset_req` is a single-cycle pulse. It is raised only when the interface leaves a disabled state that was entered through the `DIS_CYC` threshold. Recovery from the reset state or from hardware reset does not raise it.
- R7: The link counts as active only when the interface is active and `lctrl_bit` is 1. Otherwise it counts as inactive.
- R8: While the link is inactive, a `lkon_pkt_hit` pulse, or `phy_irq` high with `irq_wake_en` 1, starts `link_on_wave`. It is a square wave with a period of 2*`HALF_CYC` cycles, and it goes high one cycle after the start. `phy_irq` with `irq_wake_en` 0 does not start it, and no trigger starts it while the link is active.
- R9: When the link becomes active, `link_on_wave` is 0 within two cycles and stays 0 while the link stays active.
- R10: A `bus_reset_seen` pulse stops a link-on run that a packet or an interrupt started. It does not stop the run while `phy_irq` is high with `irq_wake_en` 1.
- R11: A `pwr_on_evt` pulse with `pwr_class` 0 to 4 runs `link_on_wave` for `PWR_CYC` cycles, or until the link becomes active if that comes first. A pulse with `pwr_class` 5 to 7 starts nothing.
- R12: In the active state, `link_ctl`, `link_data` and `link_req_out` follow `core_ctl`, `core_data` and `link_req_in` with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lps_in | input | 1 | Link power status from the link, asynchronous |
| lctrl_bit | input | 1 | Link-control register bit |
| lkon_pkt_hit | input | 1 | One-cycle strobe: a link-on packet for this node arrived |
| phy_irq | input | 1 | PHY interrupt pending (level) |
| irq_wake_en | input | 1 | Allows a pending interrupt to wake the link |
| bus_reset_seen | input | 1 | One-cycle strobe: a bus reset occurred |
| pwr_class | input | 3 | Node power class |
| pwr_on_evt | input | 1 | One-cycle strobe: power cycle completed |
| core_ctl | input | CTL_W | Control from the core toward the link |
| core_data | input | DATA_W | Data from the core toward the link |
| link_req_in | input | 1 | Request from the link toward the core |
| link_ctl | output | CTL_W | Gated control to the link |
| link_data | output | DATA_W | Gated data to the link |
| link_req_out | output | 1 | Gated request toward the core |
| link_clk_en | output | 1 | Enable for the clock sent to the link |
| bus_reset_req | output | 1 | One-cycle bus-reset request |
| link_on_wave | output | 1 | Link-on square-wave wake output |

## Verification
The bench builds the block with `RST_CYC`=20, `DIS_CYC`=60, `PWR_CYC`=200 and `HALF_CYC`=4. The defaults are realistic microsecond thresholds. These small values put both threshold edges, full recovery and the whole power-on wake window within a few hundred cycles. They also let a glitch just under the reset threshold be told apart from one just over it. A half-period of four cycles lets the bench measure the square-wave period exactly, and lets it see a stop within two cycles after the link becomes active.

// File: rtl/lpsm_pkg.sv
package lpsm_pkg;
  typedef enum logic [1:0] {
    IF_ACTIVE   = 2'd0,
    IF_RESET    = 2'd1,
    IF_DISABLED = 2'd2
  } if_state_t;
endpackage

// File: rtl/lpsm_sync.sv
module lpsm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lpsm_lowtime.sv
module lpsm_lowtime #(
  parameter int RST_CYC = 256,
  parameter int DIS_CYC = 2560
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_s,
  output logic past_rst,
  output logic past_dis
);
  localparam int CNT_MAX = DIS_CYC + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] low_q;

  // Low-time counter: any high sample clears it, and it saturates just past the disable limit
  always_ff @(posedge clk) begin
    if (rst || lps_s)                       low_q <= '0;
    else if (low_q != CNT_W'(CNT_MAX))      low_q <= low_q + 1'b1;
  end

  assign past_rst = (low_q > CNT_W'(RST_CYC));
  assign past_dis = (low_q > CNT_W'(DIS_CYC));
endmodule

// File: rtl/lpsm_ifsm.sv
module lpsm_ifsm
  import lpsm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lps_s,
  input  logic      past_rst,
  input  logic      past_dis,
  output if_state_t st,
  output logic      busrst_req
);
  if_state_t st_q;
  logic      thr_dis_q;   // set when the disabled state was reached through the threshold

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= IF_DISABLED;
      thr_dis_q  <= 1'b0;
      busrst_req <= 1'b0;
    end else begin
      busrst_req <= 1'b0;
      unique case (st_q)
        IF_ACTIVE: begin
          if (past_rst) st_q <= IF_RESET;
        end
        IF_RESET: begin
          if (lps_s) begin
            st_q <= IF_ACTIVE;
          end else if (past_dis) begin
            st_q      <= IF_DISABLED;
            thr_dis_q <= 1'b1;
          end
        end
        IF_DISABLED: begin
          if (lps_s) begin
            st_q       <= IF_ACTIVE;
            busrst_req <= thr_dis_q;
            thr_dis_q  <= 1'b0;
          end
        end
        default: st_q <= IF_DISABLED;
      endcase
    end
  end

  assign st = st_q;
endmodule

// File: rtl/lpsm_linkon.sv
module lpsm_linkon #(
  parameter int PWR_CYC  = 16417,
  parameter int HALF_CYC = 8,
  parameter int MAX_PCLS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_act,
  input  logic       lkon_pkt_hit,
  input  logic       irq_wake,
  input  logic       bus_reset_seen,
  input  logic [2:0] pwr_class,
  input  logic       pwr_on_evt,
  output logic       wave
);
  localparam int WIN_W  = $clog2(PWR_CYC + 1);
  localparam int HALF_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic             ev_q;
  logic [WIN_W-1:0] win_q;
  logic [HALF_W-1:0] half_q;
  logic             wave_q;
  logic             run;
  logic             trig;

  assign trig = lkon_pkt_hit || irq_wake;

  // Event-driven request: link activity clears it first, a new trigger beats a bus reset
  always_ff @(posedge clk) begin
    if (rst)                     ev_q <= 1'b0;
    else if (link_act)           ev_q <= 1'b0;
    else if (trig)               ev_q <= 1'b1;
    else if (bus_reset_seen)     ev_q <= 1'b0;
  end

  // Power-on wake window
  always_ff @(posedge clk) begin
    if (rst)                                          win_q <= '0;
    else if (link_act)                                win_q <= '0;
    else if (pwr_on_evt && (pwr_class <= 3'(MAX_PCLS))) win_q <= WIN_W'(PWR_CYC);
    else if (win_q != '0)                             win_q <= win_q - 1'b1;
  end

  assign run = ev_q || (win_q != '0);

  // Square-wave generator: flips on the first cycle of each half-period
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_q <= '0;
      wave_q <= 1'b0;
    end else begin
      if (half_q == '0) wave_q <= ~wave_q;
      if (half_q == HALF_W'(HALF_CYC - 1)) half_q <= '0;
      else                                 half_q <= half_q + 1'b1;
    end
  end

  assign wave = wave_q;
endmodule

// File: rtl/lps_link_mgr.sv
module lps_link_mgr
  import lpsm_pkg::*;
#(
  parameter int CTL_W    = 2,
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2,
  parameter int RST_CYC  = 256,
  parameter int DIS_CYC  = 2560,
  parameter int PWR_CYC  = 16417,
  parameter int HALF_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lps_in,
  input  logic              lctrl_bit,
  input  logic              lkon_pkt_hit,
  input  logic              phy_irq,
  input  logic              irq_wake_en,
  input  logic              bus_reset_seen,
  input  logic [2:0]        pwr_class,
  input  logic              pwr_on_evt,
  input  logic [CTL_W-1:0]  core_ctl,
  input  logic [DATA_W-1:0] core_data,
  input  logic              link_req_in,
  output logic [CTL_W-1:0]  link_ctl,
  output logic [DATA_W-1:0] link_data,
  output logic              link_req_out,
  output logic              link_clk_en,
  output logic              bus_reset_req,
  output logic              link_on_wave
);
  logic      lps_s;
  logic      past_rst;
  logic      past_dis;
  if_state_t st_q;
  logic      link_act;
  logic      pass;

  lpsm_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(lps_in), .dout(lps_s)
  );

  lpsm_lowtime #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) u_low (
    .clk(clk), .rst(rst), .lps_s(lps_s),
    .past_rst(past_rst), .past_dis(past_dis)
  );

  lpsm_ifsm u_fsm (
    .clk(clk), .rst(rst), .lps_s(lps_s),
    .past_rst(past_rst), .past_dis(past_dis),
    .st(st_q), .busrst_req(bus_reset_req)
  );

  assign link_act = (st_q == IF_ACTIVE) && lctrl_bit;

  lpsm_linkon #(.PWR_CYC(PWR_CYC), .HALF_CYC(HALF_CYC)) u_lkon (
    .clk(clk), .rst(rst), .link_act(link_act),
    .lkon_pkt_hit(lkon_pkt_hit), .irq_wake(phy_irq && irq_wake_en),
    .bus_reset_seen(bus_reset_seen), .pwr_class(pwr_class),
    .pwr_on_evt(pwr_on_evt), .wave(link_on_wave)
  );

  assign pass = (st_q == IF_ACTIVE);

  // Registered, gated link-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      link_ctl     <= '0;
      link_data    <= '0;
      link_req_out <= 1'b0;
      link_clk_en  <= 1'b0;
    end else begin
      link_ctl     <= pass ? core_ctl : '0;
      link_data    <= pass ? core_data : '0;
      link_req_out <= pass && link_req_in;
      link_clk_en  <= (st_q != IF_DISABLED);
    end
  end
endmodule

// File: rtl/lpsm_chk.sv
module lpsm_chk
  import lpsm_pkg::*;
#(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input if_state_t         st,
  input logic              lctrl_bit,
  input logic [CTL_W-1:0]  link_ctl,
  input logic [DATA_W-1:0] link_data,
  input logic              link_req_out,
  input logic              link_clk_en,
  input logic              bus_reset_req,
  input logic              link_on_wave
);
  p_gate_out_r2: assert property (@(posedge clk) disable iff (rst)
    (st != IF_ACTIVE) |=> (link_ctl == '0 && link_data == '0 && !link_req_out));

  p_clk_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (st == IF_RESET) |=> link_clk_en);

  p_clk_off_r3: assert property (@(posedge clk) disable iff (rst)
    (st == IF_DISABLED) |=> !link_clk_en);

  p_no_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (st == IF_ACTIVE) |=> (st != IF_DISABLED));

  p_busrst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bus_reset_req |=> !bus_reset_req);

  p_busrst_src_r6: assert property (@(posedge clk) disable iff (rst)
    bus_reset_req |-> (st == IF_ACTIVE && $past(st) == IF_DISABLED));

  p_wave_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (st == IF_ACTIVE && lctrl_bit) |=> ##1 !link_on_wave);
endmodule

bind lps_link_mgr lpsm_chk #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .st(st_q), .lctrl_bit(lctrl_bit),
  .link_ctl(link_ctl), .link_data(link_data), .link_req_out(link_req_out),
  .link_clk_en(link_clk_en), .bus_reset_req(bus_reset_req),
  .link_on_wave(link_on_wave)
);

// File: tb/tb_lps_link_mgr.sv
`timescale 1ns/1ps
module tb_lps_link_mgr;
  localparam int CTL_W = 2, DATA_W = 8;
  localparam int RST_CYC = 20, DIS_CYC = 60, PWR_CYC = 200, HALF_CYC = 4;

  logic clk = 0, rst = 1;
  logic lps_in = 0, lctrl_bit = 0, lkon_pkt_hit = 0, phy_irq = 0, irq_wake_en = 0;
  logic bus_reset_seen = 0, pwr_on_evt = 0, link_req_in = 0;
  logic [2:0] pwr_class = 0;
  logic [CTL_W-1:0] core_ctl = 0;
  logic [DATA_W-1:0] core_data = 0;
  logic [CTL_W-1:0] link_ctl;
  logic [DATA_W-1:0] link_data;
  logic link_req_out, link_clk_en, bus_reset_req, link_on_wave;

  int errors = 0, checks = 0;
  int brs = 0, rises = 0, last_rise = -1, last_per = 0, cyc = 0;

  always #2.5 clk = ~clk;

  lps_link_mgr #(.CTL_W(CTL_W), .DATA_W(DATA_W), .RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC),
                 .PWR_CYC(PWR_CYC), .HALF_CYC(HALF_CYC)) dut (.*);

  logic prev_wave = 0;
  always @(negedge clk) begin
    cyc++;
    if (bus_reset_req) brs++;
    if (link_on_wave && !prev_wave) begin
      rises++;
      if (last_rise >= 0) last_per = cyc - last_rise;
      last_rise = cyc;
    end
    prev_wave = link_on_wave;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    rises = 0; last_rise = -1; last_per = 0;
  endtask

  task automatic drive_core(input int v);
    core_ctl = CTL_W'(v); core_data = DATA_W'(v * 7 + 1); link_req_in = 1;
  endtask

  task automatic t_reset();
    rst = 1; cyc_wait(3); rst = 0;
    drive_core(3);
    cyc_wait(4);
    chk("R5 clk_en after reset", link_clk_en, 0);
    chk("R5 data gated after reset", link_data, 0);
    chk("R5 req gated after reset", link_req_out, 0);
    chk("R5 wave idle", link_on_wave, 0);
  endtask

  task automatic t_bringup();
    int b0 = brs;
    lps_in = 1; cyc_wait(6);
    chk("R4 clk_en on", link_clk_en, 1);
    chk("R6 no bus reset after hw reset", brs - b0, 0);
    drive_core(2); cyc_wait(1);
    chk("R12 ctl one cycle", link_ctl, 2);
    chk("R12 data one cycle", link_data, 15);
    chk("R12 req one cycle", link_req_out, 1);
  endtask

  task automatic t_glitch();
    int b0 = brs;
    lps_in = 0; cyc_wait(RST_CYC - 6);
    drive_core(1); cyc_wait(1);
    chk("R1 data passes during short low", link_data, 8);
    lps_in = 1; cyc_wait(10);
    chk("R1 still passing", link_ctl, 1);
    chk("R1 no bus reset", brs - b0, 0);
  endtask

  task automatic t_resetstate();
    int b0 = brs;
    lps_in = 0; cyc_wait(RST_CYC + 10);
    drive_core(3); cyc_wait(2);
    chk("R2 ctl forced 0", link_ctl, 0);
    chk("R2 data forced 0", link_data, 0);
    chk("R2 req ignored", link_req_out, 0);
    chk("R2 clock kept", link_clk_en, 1);
    lps_in = 1; cyc_wait(6);
    chk("R4 data back", link_data, 22);
    chk("R6 no bus reset from reset state", brs - b0, 0);
  endtask

  task automatic t_disabled();
    int b0 = brs;
    lps_in = 0; cyc_wait(DIS_CYC + 10);
    chk("R3 clock stopped", link_clk_en, 0);
    chk("R3 data gated", link_data, 0);
    lps_in = 1; cyc_wait(6);
    chk("R4 clock back", link_clk_en, 1);
    chk("R4 ctl back", link_ctl, 3);
    chk("R6 one bus reset", brs - b0, 1);
  endtask

  task automatic t_pkt_wake();
    lctrl_bit = 0; clr_mon();
    lkon_pkt_hit = 1; cyc_wait(1); lkon_pkt_hit = 0;
    cyc_wait(1);
    chk("R8 wave high one cycle after start", link_on_wave, 1);
    cyc_wait(40);
    chk("R8 wave running", (rises >= 4) ? 1 : 0, 1);
    chk("R8 period", last_per, 2 * HALF_CYC);
    lctrl_bit = 1; cyc_wait(2);
    clr_mon();
    chk("R9 wave low after link active", link_on_wave, 0);
    cyc_wait(20);
    chk("R9 stays low", rises, 0);
    lkon_pkt_hit = 1; cyc_wait(1); lkon_pkt_hit = 0; cyc_wait(20);
    chk("R7 packet ignored while active", rises, 0);
    lctrl_bit = 0;
  endtask

  task automatic t_irq_wake();
    clr_mon();
    irq_wake_en = 0; phy_irq = 1; cyc_wait(20);
    chk("R8 irq without enable", rises, 0);
    irq_wake_en = 1; cyc_wait(20);
    chk("R8 irq with enable", (rises >= 2) ? 1 : 0, 1);
    bus_reset_seen = 1; cyc_wait(1); bus_reset_seen = 0; clr_mon(); cyc_wait(20);
    chk("R10 bus reset with irq pending keeps run", (rises >= 2) ? 1 : 0, 1);
    phy_irq = 0; cyc_wait(5);
    bus_reset_seen = 1; cyc_wait(1); bus_reset_seen = 0; cyc_wait(2); clr_mon();
    cyc_wait(20);
    chk("R10 bus reset stops run", rises + link_on_wave, 0);
    irq_wake_en = 0;
  endtask

  task automatic t_power();
    clr_mon();
    pwr_class = 5; pwr_on_evt = 1; cyc_wait(1); pwr_on_evt = 0; cyc_wait(30);
    chk("R11 class 5 no wake", rises, 0);
    pwr_class = 2; pwr_on_evt = 1; cyc_wait(1); pwr_on_evt = 0; cyc_wait(PWR_CYC - 20);
    chk("R11 window running", (rises >= 10) ? 1 : 0, 1);
    cyc_wait(25); clr_mon(); cyc_wait(20);
    chk("R11 window over", rises + link_on_wave, 0);
    pwr_class = 4; pwr_on_evt = 1; cyc_wait(1); pwr_on_evt = 0; cyc_wait(30);
    lctrl_bit = 1; cyc_wait(2); clr_mon(); cyc_wait(30);
    chk("R11 window cut by active link", rises + link_on_wave, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_bringup();
    t_glitch();
    t_resetstate();
    t_disabled();
    t_pkt_wake();
    t_irq_wake();
    t_power();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule